// File: doc/BRIEF.md
# Fracturable multiplier array

This block is a pipelined multiplier array whose operand buses can be split into narrow, medium or wide independent multipliers. A two-bit mode input selects the split. Both 72-bit operand buses and the 144-bit result bus are shared by all three splits. The narrow split gives eight 9×9 products, the medium split gives six 12×12 products and the wide split gives four 18×18 products. Each lane reads its own operand slices and writes its own result slice. Run-time controls choose how each operand is read. The A operands can be unsigned or two's complement, and the B operands can be chosen the same way on their own. Optional rounding and optional saturation act on every lane, and each lane has an overflow flag that reports a clamp.

The operands and controls pass through an input register bank, and the results pass through an output register bank. Each bank has its own enable, and one asynchronous clear resets both banks. When the mode input changes, the pipeline is flushed so that a result from one split never appears under another split. A package function maps an arbitrary operand width to the narrowest split that holds it, and gives the number of zero bits to append below the operand.

Top module: `fracMulArray`

## Requirements
- R1: Mode code 0 gives eight 9-bit lanes: lane i uses opA/opB bits [9i+8:9i] and writes result bits [18i+17:18i]. Code 1 gives six 12-bit lanes: operands at [12i+11:12i] and results at [24i+23:24i]. Codes 2 and 3 both give four 18-bit lanes: operands at [18i+17:18i] and results at [36i+35:36i].
- R2: When signA is 1, the A operands are two's complement; when it is 0 they are unsigned. signB does the same for the B operands. With rounding and saturation off, an N-bit lane result is the low 2N bits of the exact product and its overflow bit is 0.
- R3: At a clock edge with inEn high, the input bank captures the operands and the signA, signB, roundEn and satEn controls. At a clock edge with outEn high, the output bank captures the lane results. A result therefore appears two edges after its operands are driven. A bank whose enable is low keeps its contents.
- R4: While clrAsync is high, result and overflow are zero at once, with no clock edge needed. The input bank and the mode in use (code 0) are cleared as well.
- R5: With roundEn set, 2^(N-1) is added to the lane product, and then the low N bits of the lane result are forced to zero.
- R6: With satEn set, the sum after rounding is clamped to the range from -2^(2N-2) to 2^(2N-2)-1, and overflow bit i goes high in the cycle that lane i's clamped result is shown. Clamping comes before the low bits are forced to zero. Overflow bits above the active lane count are always 0.
- R7: A mode input that differs from the mode in use clears both banks at the next clock edge, even if the enables are low. The new mode takes effect from that edge.
- R8: fmaModeFor(w) returns 0 for w≤9, 1 for 10≤w≤12 and 2 for 13≤w≤18. fmaPadFor(w) returns the lane width minus w. An operand padded with that many low zeros gives a lane result equal to the true product shifted left by twice the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clrAsync | input | 1 | Asynchronous clear of both register banks, active high |
| mode | input | 2 | Lane split: 0 narrow, 1 medium, 2 or 3 wide |
| inEn | input | 1 | Input bank enable |
| outEn | input | 1 | Output bank enable |
| signA | input | 1 | A operands are two's complement when 1 |
| signB | input | 1 | B operands are two's complement when 1 |
| roundEn | input | 1 | Round to the upper half of each lane result |
| satEn | input | 1 | Clamp each lane result and report overflow |
| opA | input | 72 | Packed A operands |
| opB | input | 72 | Packed B operands |
| result | output | 144 | Packed lane results |
| overflow | output | 8 | Per-lane saturation flag |

## Verification
The hardest corner to reach from the ports is saturation. A signed product never goes beyond 2N bits, so a clamp only happens in a few cases. One is the most negative value times itself. Another is a large unsigned product, or an unsigned product pushed over the limit by the rounding constant. The stimulus puts the signed minimum, all-ones, zero, one and the signed maximum on the lanes in shifting combinations, and runs every split under all four signedness settings with each rounding and saturation pairing. One case places the minimum on both operands of every lane. The flush is driven by changing the mode while a nonzero result is held, once with the output enable low.

// File: rtl/fmaPkg.sv
package fmaPkg;
  localparam int SMALL_W = 9;
  localparam int MID_W   = 12;
  localparam int WIDE_W  = 18;
  localparam int BUS_W   = 4 * WIDE_W;
  localparam int RES_W   = 2 * BUS_W;
  localparam int SMALL_N = BUS_W / SMALL_W;
  localparam int MID_N   = BUS_W / MID_W;
  localparam int WIDE_N  = BUS_W / WIDE_W;
  localparam int MAX_N   = SMALL_N;

  typedef enum logic [1:0] {
    MODE_SMALL    = 2'd0,
    MODE_MID      = 2'd1,
    MODE_WIDE     = 2'd2,
    MODE_WIDE_ALT = 2'd3
  } laneMode_t;

  typedef struct packed {
    logic      loadIn;
    logic      loadOut;
    logic      flush;
    laneMode_t mode;
  } fmaCtl_t;

  // narrowest split that holds a w-bit operand
  function automatic laneMode_t fmaModeFor(input int w);
    if (w <= SMALL_W) return MODE_SMALL;
    if (w <= MID_W) return MODE_MID;
    return MODE_WIDE;
  endfunction

  // zero bits appended below a w-bit operand to fill its lane
  function automatic int fmaPadFor(input int w);
    case (fmaModeFor(w))
      MODE_SMALL: return SMALL_W - w;
      MODE_MID:   return MID_W - w;
      default:    return WIDE_W - w;
    endcase
  endfunction
endpackage

// File: rtl/fmaCtrl.sv
module fmaCtrl
  import fmaPkg::*;
(
  input  logic       clk,
  input  logic       clrAsync,
  input  logic [1:0] modeIn,
  input  logic       inEn,
  input  logic       outEn,
  output fmaCtl_t    ctl
);
  laneMode_t modeQ;
  logic      modeChange;

  assign modeChange = (laneMode_t'(modeIn) != modeQ);

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) modeQ <= MODE_SMALL;
    else          modeQ <= laneMode_t'(modeIn);
  end

  always_comb begin
    ctl.flush   = modeChange;
    ctl.loadIn  = inEn & ~modeChange;
    ctl.loadOut = outEn & ~modeChange;
    ctl.mode    = modeQ;
  end
endmodule

// File: rtl/fmaLane.sv
module fmaLane #(
  parameter int N = 9
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  input  logic           sa,
  input  logic           sb,
  input  logic           rnd,
  input  logic           sat,
  output logic [2*N-1:0] res,
  output logic           ovf
);
  localparam int PW = 2 * N + 2;
  localparam logic signed [PW-1:0] MAXV = (PW'(1) << (2 * N - 2)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = ~MAXV;
  localparam logic [PW-1:0] LOWMASK = (PW'(1) << N) - PW'(1);

  logic signed [N:0]    aX, bX;
  logic signed [PW-1:0] prod, sum, kept;
  logic                 unusedHi;

  assign aX = {sa & a[N-1], a};
  assign bX = {sb & b[N-1], b};

  always_comb begin
    prod = PW'(aX) * PW'(bX);
    sum  = prod + $signed(rnd ? (PW'(1) << (N - 1)) : PW'(0));
    kept = sum;
    ovf  = 1'b0;
    if (sat) begin
      if (sum > MAXV) begin
        kept = MAXV;
        ovf  = 1'b1;
      end else if (sum < MINV) begin
        kept = MINV;
        ovf  = 1'b1;
      end
    end
    if (rnd) kept = kept & ~LOWMASK;
  end

  assign res      = kept[2*N-1:0];
  assign unusedHi = ^kept[PW-1:2*N];
endmodule

// File: rtl/fmaDatapath.sv
module fmaDatapath
  import fmaPkg::*;
(
  input  logic             clk,
  input  logic             clrAsync,
  input  fmaCtl_t          ctl,
  input  logic [BUS_W-1:0] opA,
  input  logic [BUS_W-1:0] opB,
  input  logic             signA,
  input  logic             signB,
  input  logic             roundEn,
  input  logic             satEn,
  output logic [RES_W-1:0] result,
  output logic [MAX_N-1:0] overflow
);
  logic [BUS_W-1:0] aQ, bQ;
  logic             sgnAQ, sgnBQ, rndQ, satQ;
  logic [RES_W-1:0] resS, resM, resW, resNext;
  logic [MAX_N-1:0] ovS, ovM, ovW, ovNext;

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) begin
      aQ <= '0; bQ <= '0;
      sgnAQ <= 1'b0; sgnBQ <= 1'b0; rndQ <= 1'b0; satQ <= 1'b0;
    end else if (ctl.flush) begin
      aQ <= '0; bQ <= '0;
      sgnAQ <= 1'b0; sgnBQ <= 1'b0; rndQ <= 1'b0; satQ <= 1'b0;
    end else if (ctl.loadIn) begin
      aQ <= opA; bQ <= opB;
      sgnAQ <= signA; sgnBQ <= signB; rndQ <= roundEn; satQ <= satEn;
    end
  end

  generate
    for (genvar gi = 0; gi < SMALL_N; gi++) begin : gSmall
      fmaLane #(.N(SMALL_W)) uLane (
        .a(aQ[gi*SMALL_W +: SMALL_W]), .b(bQ[gi*SMALL_W +: SMALL_W]),
        .sa(sgnAQ), .sb(sgnBQ), .rnd(rndQ), .sat(satQ),
        .res(resS[gi*2*SMALL_W +: 2*SMALL_W]), .ovf(ovS[gi]));
    end
    if (SMALL_N < MAX_N) begin : gSmallPad
      assign ovS[MAX_N-1:SMALL_N] = '0;
    end

    for (genvar gi = 0; gi < MID_N; gi++) begin : gMid
      fmaLane #(.N(MID_W)) uLane (
        .a(aQ[gi*MID_W +: MID_W]), .b(bQ[gi*MID_W +: MID_W]),
        .sa(sgnAQ), .sb(sgnBQ), .rnd(rndQ), .sat(satQ),
        .res(resM[gi*2*MID_W +: 2*MID_W]), .ovf(ovM[gi]));
    end
    if (MID_N < MAX_N) begin : gMidPad
      assign ovM[MAX_N-1:MID_N] = '0;
    end

    for (genvar gi = 0; gi < WIDE_N; gi++) begin : gWide
      fmaLane #(.N(WIDE_W)) uLane (
        .a(aQ[gi*WIDE_W +: WIDE_W]), .b(bQ[gi*WIDE_W +: WIDE_W]),
        .sa(sgnAQ), .sb(sgnBQ), .rnd(rndQ), .sat(satQ),
        .res(resW[gi*2*WIDE_W +: 2*WIDE_W]), .ovf(ovW[gi]));
    end
    if (WIDE_N < MAX_N) begin : gWidePad
      assign ovW[MAX_N-1:WIDE_N] = '0;
    end
  endgenerate

  always_comb begin
    case (ctl.mode)
      MODE_SMALL: begin resNext = resS; ovNext = ovS; end
      MODE_MID:   begin resNext = resM; ovNext = ovM; end
      default:    begin resNext = resW; ovNext = ovW; end
    endcase
  end

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) begin
      result <= '0; overflow <= '0;
    end else if (ctl.flush) begin
      result <= '0; overflow <= '0;
    end else if (ctl.loadOut) begin
      result <= resNext; overflow <= ovNext;
    end
  end
endmodule

// File: rtl/fracMulArray.sv
module fracMulArray
  import fmaPkg::*;
(
  input  logic             clk,
  input  logic             clrAsync,
  input  logic [1:0]       mode,
  input  logic             inEn,
  input  logic             outEn,
  input  logic             signA,
  input  logic             signB,
  input  logic             roundEn,
  input  logic             satEn,
  input  logic [BUS_W-1:0] opA,
  input  logic [BUS_W-1:0] opB,
  output logic [RES_W-1:0] result,
  output logic [MAX_N-1:0] overflow
);
  fmaCtl_t ctl;

  fmaCtrl u_ctrl (
    .clk(clk), .clrAsync(clrAsync), .modeIn(mode),
    .inEn(inEn), .outEn(outEn), .ctl(ctl));

  fmaDatapath u_datapath (
    .clk(clk), .clrAsync(clrAsync), .ctl(ctl),
    .opA(opA), .opB(opB), .signA(signA), .signB(signB),
    .roundEn(roundEn), .satEn(satEn),
    .result(result), .overflow(overflow));
endmodule

// File: rtl/fmaChecker.sv
module fmaChecker
  import fmaPkg::*;
(
  input logic             clk,
  input logic             clrAsync,
  input logic [1:0]       mode,
  input logic             outEn,
  input logic [RES_W-1:0] result,
  input logic [MAX_N-1:0] overflow
);
  localparam int LW = 2 * WIDE_W;
  localparam logic [LW-1:0] SAT_HI     = (LW'(1) << (LW - 2)) - LW'(1);
  localparam logic [LW-1:0] SAT_HI_RND = SAT_HI & ~((LW'(1) << WIDE_W) - LW'(1));
  localparam logic [LW-1:0] SAT_LO     = ~SAT_HI;

  // R3: a disabled output bank keeps its value
  p_hold_out_r3: assert property (@(posedge clk) disable iff (clrAsync)
    (!outEn && $stable(mode)) |=> ($stable(result) && $stable(overflow)));

  // R7: a mode change empties the output bank at the next edge
  p_flush_r7: assert property (@(posedge clk) disable iff (clrAsync)
    (mode != $past(mode)) |=> (result == '0 && overflow == '0));

  // R6: no overflow flag above the active lane count
  p_ovf_mid_lanes_r6: assert property (@(posedge clk) disable iff (clrAsync)
    ($stable(mode) && mode == 2'd1) |-> (overflow[MAX_N-1:MID_N] == '0));

  p_ovf_wide_lanes_r6: assert property (@(posedge clk) disable iff (clrAsync)
    ($stable(mode) && mode[1]) |-> (overflow[MAX_N-1:WIDE_N] == '0));

  // R6: a flagged wide lane holds one of the clamp values
  p_sat_value_r6: assert property (@(posedge clk) disable iff (clrAsync)
    ($stable(mode) && mode[1] && overflow[0]) |->
      (result[LW-1:0] == SAT_HI || result[LW-1:0] == SAT_HI_RND || result[LW-1:0] == SAT_LO));
endmodule

bind fracMulArray fmaChecker u_chk (
  .clk(clk), .clrAsync(clrAsync), .mode(mode), .outEn(outEn),
  .result(result), .overflow(overflow));

// File: tb/fracMulArray_bench.sv
module fracMulArray_bench;
  import fmaPkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, clrAsync = 1'b1;
  logic [1:0] mode = 2'd0;
  logic inEn = 1'b0, outEn = 1'b0, signA = 1'b0, signB = 1'b0, roundEn = 1'b0, satEn = 1'b0;
  logic [BUS_W-1:0] opA = '0, opB = '0;
  logic [RES_W-1:0] result;
  logic [MAX_N-1:0] overflow;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracMulArray u_fracMulArray (
    .clk(clk), .clrAsync(clrAsync), .mode(mode), .inEn(inEn), .outEn(outEn),
    .signA(signA), .signB(signB), .roundEn(roundEn), .satEn(satEn),
    .opA(opA), .opB(opB), .result(result), .overflow(overflow));

  task automatic check(input bit ok, input string req, input string what, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int laneW(input int m);
    return (m == 0) ? 9 : (m == 1) ? 12 : 18;
  endfunction

  // expected lane value from the requirements
  function automatic longint laneRef(input int n, input longint a, input longint b,
                                     input bit sa, input bit sb, input bit rnd, input bit sat,
                                     output bit o);
    longint av, bv, s, maxv, minv;
    av = a; bv = b;
    if (sa && a[n-1]) av = a - (longint'(1) << n);
    if (sb && b[n-1]) bv = b - (longint'(1) << n);
    s = av * bv + (rnd ? (longint'(1) << (n - 1)) : 0);
    maxv = (longint'(1) << (2*n - 2)) - 1;
    minv = -(longint'(1) << (2*n - 2));
    o = 1'b0;
    if (sat) begin
      if (s > maxv) begin s = maxv; o = 1'b1; end
      else if (s < minv) begin s = minv; o = 1'b1; end
    end
    if (rnd) s = s & ~((longint'(1) << n) - 1);
    return s & ((longint'(1) << (2*n)) - 1);
  endfunction

  function automatic longint extVal(input int n, input int k);
    case (k % 5)
      0: return 0;
      1: return 1;
      2: return (longint'(1) << n) - 1;
      3: return longint'(1) << (n - 1);
      default: return (longint'(1) << (n - 1)) - 1;
    endcase
  endfunction

  function automatic longint pat(input int n, input int p, input int i, input bit side);
    if (p < 5) return extVal(n, side ? (p + 2*i + 1) : (p + i));
    return longint'($urandom) & ((longint'(1) << n) - 1);
  endfunction

  task automatic setMode(input int m);
    @(negedge clk);
    mode = 2'(m); inEn = 1'b1; outEn = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic runLanes(input int m, input longint av[MAX_N], input longint bv[MAX_N],
                          input bit sa, input bit sb, input bit rnd, input bit sat, input string req);
    int n, cnt;
    longint lmask, rmask;
    logic [BUS_W-1:0] pa, pb;
    n = laneW(m); cnt = BUS_W / n;
    lmask = (longint'(1) << n) - 1;
    rmask = (longint'(1) << (2*n)) - 1;
    pa = '0; pb = '0;
    for (int i = 0; i < cnt; i++) begin
      pa = pa | (BUS_W'(av[i] & lmask) << (i*n));
      pb = pb | (BUS_W'(bv[i] & lmask) << (i*n));
    end
    @(negedge clk);
    opA = pa; opB = pb; signA = sa; signB = sb; roundEn = rnd; satEn = sat;
    inEn = 1'b1; outEn = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < MAX_N; i++) begin
      bit eo;
      longint ev, gv;
      logic [RES_W-1:0] sh;
      eo = 1'b0;
      if (i < cnt) begin
        ev = laneRef(n, av[i] & lmask, bv[i] & lmask, sa, sb, rnd, sat, eo);
        sh = result >> (i*2*n);
        gv = longint'(sh[63:0]) & rmask;
        check(gv == ev, req, $sformatf("mode %0d lane %0d result", m, i), gv, ev);
      end
      check(overflow[i] == eo, req, $sformatf("mode %0d lane %0d overflow", m, i),
            longint'(overflow[i]), longint'(eo));
    end
  endtask

  task automatic tReset();
    check(result == '0, "R4", "result after reset", longint'(result[63:0]), 0);
    check(overflow == '0, "R4", "overflow after reset", longint'(overflow), 0);
  endtask

  task automatic tModeSweep(input int m);
    setMode(m);
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 9; p++) begin
        longint av[MAX_N], bv[MAX_N];
        for (int i = 0; i < MAX_N; i++) begin
          av[i] = pat(laneW(m), p, i, 1'b0);
          bv[i] = pat(laneW(m), p, i, 1'b1);
        end
        runLanes(m, av, bv, s[0], s[1], 1'b0, 1'b0, (s == 0) ? "R1" : "R2");
      end
    end
  endtask

  task automatic tRoundSat();
    for (int m = 0; m < 3; m++) begin
      setMode(m);
      for (int s = 0; s < 4; s++) begin
        for (int c = 1; c < 4; c++) begin
          for (int p = 0; p < 7; p++) begin
            longint av[MAX_N], bv[MAX_N];
            for (int i = 0; i < MAX_N; i++) begin
              av[i] = pat(laneW(m), p, i, 1'b0);
              bv[i] = pat(laneW(m), p, i, 1'b1);
            end
            runLanes(m, av, bv, s[0], s[1], c[0], c[1], (c == 1) ? "R5" : "R6");
          end
        end
      end
      begin
        longint av[MAX_N], bv[MAX_N];
        int cnt;
        cnt = BUS_W / laneW(m);
        for (int i = 0; i < MAX_N; i++) begin
          av[i] = extVal(laneW(m), 3);
          bv[i] = extVal(laneW(m), 3);
        end
        runLanes(m, av, bv, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
        for (int i = 0; i < cnt; i++)
          check(overflow[i] == 1'b1, "R6", $sformatf("min*min flag mode %0d lane %0d", m, i),
                longint'(overflow[i]), 1);
      end
    end
  endtask

  task automatic tEnables();
    setMode(2);
    @(negedge clk);
    signA = 1'b0; signB = 1'b0; roundEn = 1'b0; satEn = 1'b0;
    opA = BUS_W'(3); opB = BUS_W'(5); inEn = 1'b1; outEn = 1'b1;
    repeat (2) @(negedge clk);
    check(result[35:0] == 36'd15, "R3", "two-edge latency", longint'(result[35:0]), 15);
    opA = BUS_W'(7); opB = BUS_W'(11);
    @(negedge clk);
    check(result[35:0] == 36'd15, "R3", "one edge not enough", longint'(result[35:0]), 15);
    @(negedge clk);
    check(result[35:0] == 36'd77, "R3", "second edge", longint'(result[35:0]), 77);
    outEn = 1'b0; opA = BUS_W'(2); opB = BUS_W'(9);
    repeat (3) @(negedge clk);
    check(result[35:0] == 36'd77, "R3", "output bank hold", longint'(result[35:0]), 77);
    outEn = 1'b1; inEn = 1'b0; opA = BUS_W'(4); opB = BUS_W'(4);
    @(negedge clk);
    check(result[35:0] == 36'd18, "R3", "input bank loaded while output held", longint'(result[35:0]), 18);
    repeat (2) @(negedge clk);
    check(result[35:0] == 36'd18, "R3", "input bank hold", longint'(result[35:0]), 18);
    inEn = 1'b1;
  endtask

  task automatic tModeFlush();
    longint av[MAX_N], bv[MAX_N];
    for (int i = 0; i < MAX_N; i++) begin av[i] = 5; bv[i] = 7; end
    setMode(0);
    runLanes(0, av, bv, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    mode = 2'd1;
    @(negedge clk);
    check(result == '0, "R7", "flush on mode change", longint'(result[63:0]), 0);
    check(overflow == '0, "R7", "overflow flushed", longint'(overflow), 0);
    repeat (2) @(negedge clk);
    runLanes(1, av, bv, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    outEn = 1'b0; mode = 2'd2;
    @(negedge clk);
    check(result == '0, "R7", "flush with output bank disabled", longint'(result[63:0]), 0);
    outEn = 1'b1;
    repeat (2) @(negedge clk);
    runLanes(2, av, bv, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
  endtask

  task automatic tAsyncClear();
    longint av[MAX_N], bv[MAX_N];
    for (int i = 0; i < MAX_N; i++) begin av[i] = 100 + i; bv[i] = 3; end
    setMode(0);
    runLanes(0, av, bv, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    #2 clrAsync = 1'b1;
    #1;
    check(result == '0, "R4", "async clear result", longint'(result[63:0]), 0);
    check(overflow == '0, "R4", "async clear overflow", longint'(overflow), 0);
    @(negedge clk);
    clrAsync = 1'b0; inEn = 1'b0; outEn = 1'b1;
    @(negedge clk);
    check(result == '0, "R4", "input bank cleared", longint'(result[63:0]), 0);
    inEn = 1'b1;
  endtask

  task automatic tWidthMap();
    longint av[MAX_N], bv[MAX_N];
    longint a7[MAX_N], b7[MAX_N];
    int pad;
    check(fmaModeFor(1) == MODE_SMALL, "R8", "map 1", longint'(fmaModeFor(1)), 0);
    check(fmaModeFor(9) == MODE_SMALL, "R8", "map 9", longint'(fmaModeFor(9)), 0);
    check(fmaModeFor(10) == MODE_MID, "R8", "map 10", longint'(fmaModeFor(10)), 1);
    check(fmaModeFor(12) == MODE_MID, "R8", "map 12", longint'(fmaModeFor(12)), 1);
    check(fmaModeFor(13) == MODE_WIDE, "R8", "map 13", longint'(fmaModeFor(13)), 2);
    check(fmaModeFor(18) == MODE_WIDE, "R8", "map 18", longint'(fmaModeFor(18)), 2);
    check(fmaPadFor(7) == 2, "R8", "pad 7", longint'(fmaPadFor(7)), 2);
    check(fmaPadFor(13) == 5, "R8", "pad 13", longint'(fmaPadFor(13)), 5);
    a7 = '{-64, 63, -1, 5, 63, -64, 0, -7};
    b7 = '{-64, -64, 1, 9, 63, 63, -5, -3};
    pad = fmaPadFor(7);
    for (int i = 0; i < MAX_N; i++) begin
      av[i] = (a7[i] << pad) & 511;
      bv[i] = (b7[i] << pad) & 511;
    end
    setMode(int'(fmaModeFor(7)));
    runLanes(0, av, bv, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    for (int i = 0; i < MAX_N; i++) begin
      logic [RES_W-1:0] sh;
      longint g;
      sh = result >> (i*18);
      g = longint'(sh[17:0]);
      if (g[17]) g = g - (longint'(1) << 18);
      check((g >>> (2*pad)) == a7[i] * b7[i], "R8", $sformatf("padded lane %0d", i),
            g >>> (2*pad), a7[i] * b7[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    clrAsync = 1'b0;
    @(negedge clk);
    tReset();
    tModeSweep(0);
    tModeSweep(1);
    tModeSweep(2);
    tModeSweep(3);
    tRoundSat();
    tEnables();
    tModeFlush();
    tAsyncClear();
    tWidthMap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule